// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit, 1024-word first-in first-out buffer whose write and read ports run on independent clocks. A word is stored on every write-clock edge with the write request high, and is returned in arrival order through a registered read port. The read port's output can be gated to zero by an output enable. Five status outputs report the fill level: empty, almost empty, half full, almost full and full.

The two thresholds behind the almost-empty and almost-full flags live in a pair of 12-bit offset registers. With the offset-load strobe high, write edges fill these registers from the low data bits instead of the storage. Read edges under the same strobe return their contents on the data output. The registers are always visited in a fixed alternating order: the empty-side offset first, then the full-side offset.

A rewind input returns the read pointer to storage location zero, so data already read can be sent again. It is valid while no more than one depth of words has been written since reset.

Pointers cross between the clock domains as Gray codes through two-stage synchronizers. Each flag is driven only by registers of its own clock domain. The offset registers are configuration, changed only while the opposite port is idle.

Top module: `dcfifo_pflag`

## Requirements
- R1: Each write-clock edge with `wr_req` high, `ofs_load` low and `full` low stores `wr_data`. Each read-clock edge with `rd_req` high, `ofs_load` low, `rd_rewind` low and `empty` low loads the oldest unread word into the output register. With `rd_oe` high, that word is visible on `rd_data` right after that edge, and words come out in write order.
- R2: `empty` is high while the read side sees no unread word. After a write into an empty buffer, `empty` stays high for two read edges and is low after the second read edge following the write edge.
- R3: `full` is high when 1024 words are held. A write request while full is ignored: no word is stored and the pointer does not move.
- R4: A read request while `empty` is high is ignored. `rd_data` keeps its previous value, and the next word written is the next word read.
- R5: `almost_empty` is high exactly when the number of held words is less than or equal to the empty-side offset.
- R6: `almost_full` is high exactly when 1024 minus the number of held words is less than or equal to the full-side offset.
- R7: `half_full` is high exactly when 513 or more words are held.
- R8: While `ofs_load` is high, write-enabled edges load `wr_data[11:0]` into the offset registers and store nothing in the buffer. The registers alternate in a fixed order: the empty-side offset first, then the full-side offset, then the empty-side offset again.
- R9: While `ofs_load` is high, read-enabled edges place an offset on `rd_data`, zero-extended to 18 bits. They follow the same alternating order, starting with the empty-side offset after reset, and do not move the read pointer.
- R10: After reset both offsets are 127, both load and readback sequences restart at the empty-side offset, and `rd_data` is 0. Also after reset, `empty` and `almost_empty` are 1, and `full`, `almost_full` and `half_full` are 0.
- R11: A read edge with `rd_rewind` high sets the read pointer to location 0. The next read returns the first word written since reset.
- R12: With `rd_oe` low, `rd_data` is 0. With it high, `rd_data` shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Synchronous active-high reset, write domain |
| wr_req | input | 1 | Write request |
| wr_data | input | 18 | Write data; bits 11:0 also feed the offset registers |
| ofs_load | input | 1 | Redirects writes and reads to the offset registers |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Synchronous active-high reset, read domain |
| rd_req | input | 1 | Read request |
| rd_oe | input | 1 | Output enable for rd_data |
| rd_rewind | input | 1 | Rewinds the read pointer to location 0 |
| rd_data | output | 18 | Registered read data, gated by rd_oe |
| empty | output | 1 | No unread word (read domain) |
| almost_empty | output | 1 | Held words at or below the empty-side offset (read domain) |
| half_full | output | 1 | At least 513 words held (write domain) |
| almost_full | output | 1 | Free space at or below the full-side offset (write domain) |
| full | output | 1 | 1024 words held (write domain) |

## Verification
The bench sweeps offset pairs and fill levels that straddle each threshold by one word, including 512 and 513 words for half full and an exactly full buffer. A design with an off-by-one comparison flips exactly one of those flags at its edge. It pushes one extra word into a full buffer and drains, so a design that accepts an overflow write shows up as a wrong word or a buffer that is not empty at the end. It reads from an empty buffer and then writes, which exposes a pointer that advanced on the ignored read. It also counts the two-edge delay before `empty` clears, reloads the offsets past their pair to catch a broken alternation, and rewinds after partial reads, so a rewind that lands anywhere but word zero returns the wrong data.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    // Which offset register the load / readback sequencer points at.
    typedef enum logic {
        OFS_LOW_MARK  = 1'b0,
        OFS_HIGH_MARK = 1'b1
    } ofs_sel_e;

    // Fixed visiting order: low-side mark first, then high-side mark.
    function automatic ofs_sel_e ofs_advance(input ofs_sel_e cur);
        return (cur == OFS_LOW_MARK) ? OFS_HIGH_MARK : OFS_LOW_MARK;
    endfunction

endpackage

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
    parameter int PTR_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] gray_in,
    output logic [PTR_W-1:0] bin_out
);
    logic [PTR_W-1:0] stage1;
    logic [PTR_W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= gray_in;
            stage2 <= stage1;
        end
    end

    // Gray to binary after the second stage.
    always_comb begin
        for (int i = 0; i < PTR_W; i++) begin
            bin_out[i] = ^(stage2 >> i);
        end
    end
endmodule

// File: rtl/fifo_dp_ram.sv
module fifo_dp_ram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
    import fifo_pf_pkg::*;
#(
    parameter int ADDR_W  = 10,
    parameter int OFF_W   = 12,
    parameter int OFF_RST = 127,
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic              ofs_load,
    input  logic [OFF_W-1:0]  ofs_din,
    input  logic [PTR_W-1:0]  rd_bin_sync,
    output logic [PTR_W-1:0]  wr_gray,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              wr_fire,
    output logic              full,
    output logic              almost_full,
    output logic              half_full,
    output logic [OFF_W-1:0]  low_mark,
    output logic [OFF_W-1:0]  high_mark
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int HALF  = DEPTH / 2;

    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] wbin_nx;
    logic [PTR_W-1:0] held;
    ofs_sel_e         load_sel;

    assign held        = wbin - rd_bin_sync;
    assign full        = (held == PTR_W'(DEPTH));
    assign half_full   = (32'(held) > 32'(HALF));
    assign almost_full = ((32'(DEPTH) - 32'(held)) <= 32'(high_mark));
    assign wr_fire     = wr_req && !ofs_load && !full;
    assign wr_addr     = wbin[ADDR_W-1:0];
    assign wbin_nx     = wbin + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin      <= '0;
            wr_gray   <= '0;
            load_sel  <= OFS_LOW_MARK;
            low_mark  <= OFF_W'(OFF_RST);
            high_mark <= OFF_W'(OFF_RST);
        end else begin
            if (wr_fire) begin
                wbin    <= wbin_nx;
                wr_gray <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (ofs_load && wr_req) begin
                if (load_sel == OFS_LOW_MARK) begin
                    low_mark <= ofs_din;
                end else begin
                    high_mark <= ofs_din;
                end
                load_sel <= ofs_advance(load_sel);
            end
        end
    end

    // R3: a request against a full buffer leaves the write pointer in place
    assert_full_blocks_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_req && full) |=> $stable(wbin));

    // R3: the held count never exceeds the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (32'(held) <= 32'(DEPTH)));

    // R8: an offset load never advances the storage pointer
    assert_load_no_store_R8: assert property (@(posedge clk) disable iff (rst)
        (ofs_load && wr_req) |=> $stable(wbin));
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side
    import fifo_pf_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int OFF_W  = 12,
    localparam int PTR_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              ofs_load,
    input  logic              rewind,
    input  logic [PTR_W-1:0]  wr_bin_sync,
    input  logic [OFF_W-1:0]  low_mark,
    input  logic [OFF_W-1:0]  high_mark,
    output logic [PTR_W-1:0]  rd_gray,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              rd_fire,
    output logic              empty,
    output logic              almost_empty,
    output logic [OFF_W-1:0]  ofs_q,
    output logic              show_ofs
);
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] rbin_nx;
    logic [PTR_W-1:0] unread;
    ofs_sel_e         peek_sel;

    assign unread       = wr_bin_sync - rbin;
    assign empty        = (unread == '0);
    assign almost_empty = (32'(unread) <= 32'(low_mark));
    assign rd_fire      = rd_req && !ofs_load && !rewind && !empty;
    assign rd_addr      = rbin[ADDR_W-1:0];
    assign rbin_nx      = rbin + PTR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin     <= '0;
            rd_gray  <= '0;
            peek_sel <= OFS_LOW_MARK;
            ofs_q    <= '0;
            show_ofs <= 1'b0;
        end else begin
            if (rewind) begin
                rbin    <= '0;
                rd_gray <= '0;
            end else if (rd_fire) begin
                rbin    <= rbin_nx;
                rd_gray <= rbin_nx ^ (rbin_nx >> 1);
            end
            if (ofs_load && rd_req) begin
                ofs_q    <= (peek_sel == OFS_LOW_MARK) ? low_mark : high_mark;
                peek_sel <= ofs_advance(peek_sel);
                show_ofs <= 1'b1;
            end else if (rd_fire) begin
                show_ofs <= 1'b0;
            end
        end
    end

    // R4: reading an empty buffer does not move the read pointer
    assert_empty_read_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty && !rewind) |=> $stable(rbin));

    // R9: offset readback does not pop
    assert_readback_no_pop_R9: assert property (@(posedge clk) disable iff (rst)
        (ofs_load && rd_req && !rewind) |=> $stable(rbin));

    // R11: rewind lands on location zero
    assert_rewind_to_zero_R11: assert property (@(posedge clk) disable iff (rst)
        rewind |=> (rbin == '0));
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag #(
    parameter int DATA_W  = 18,
    parameter int ADDR_W  = 10,
    parameter int OFF_W   = 12,
    parameter int OFF_RST = 127
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ofs_load,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_req,
    input  logic              rd_oe,
    input  logic              rd_rewind,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              almost_empty,
    output logic              half_full,
    output logic              almost_full,
    output logic              full
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_gray, rd_gray;
    logic [PTR_W-1:0]  wr_bin_at_rd, rd_bin_at_wr;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_fire, rd_fire;
    logic [OFF_W-1:0]  low_mark, high_mark, ofs_q;
    logic              show_ofs;
    logic [DATA_W-1:0] ram_q;

    fifo_wr_side #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .OFF_RST(OFF_RST)) u_wr (
        .clk(wclk), .rst(wrst), .wr_req(wr_req), .ofs_load(ofs_load),
        .ofs_din(wr_data[OFF_W-1:0]), .rd_bin_sync(rd_bin_at_wr),
        .wr_gray(wr_gray), .wr_addr(wr_addr), .wr_fire(wr_fire),
        .full(full), .almost_full(almost_full), .half_full(half_full),
        .low_mark(low_mark), .high_mark(high_mark)
    );

    fifo_rd_side #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_rd (
        .clk(rclk), .rst(rrst), .rd_req(rd_req), .ofs_load(ofs_load),
        .rewind(rd_rewind), .wr_bin_sync(wr_bin_at_rd),
        .low_mark(low_mark), .high_mark(high_mark),
        .rd_gray(rd_gray), .rd_addr(rd_addr), .rd_fire(rd_fire),
        .empty(empty), .almost_empty(almost_empty),
        .ofs_q(ofs_q), .show_ofs(show_ofs)
    );

    fifo_ptr_sync #(.PTR_W(PTR_W)) u_w2r (
        .clk(rclk), .rst(rrst), .gray_in(wr_gray), .bin_out(wr_bin_at_rd)
    );

    fifo_ptr_sync #(.PTR_W(PTR_W)) u_r2w (
        .clk(wclk), .rst(wrst), .gray_in(rd_gray), .bin_out(rd_bin_at_wr)
    );

    fifo_dp_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
        .wclk(wclk), .we(wr_fire), .waddr(wr_addr), .wdata(wr_data),
        .rclk(rclk), .rrst(rrst), .re(rd_fire), .raddr(rd_addr), .rdata(ram_q)
    );

    // R12: output enable gates the registered read path
    assign rd_data = rd_oe ? (show_ofs ? DATA_W'(ofs_q) : ram_q) : '0;

    // R5: a buffer the read side sees as empty is also almost empty
    assert_empty_in_low_band_R5: assert property (@(posedge rclk) disable iff (rrst)
        empty |-> almost_empty);

    // R6 / R7: a full buffer is inside both upper bands
    assert_full_in_high_band_R6: assert property (@(posedge wclk) disable iff (wrst)
        full |-> almost_full);
    assert_full_over_half_R7: assert property (@(posedge wclk) disable iff (wrst)
        full |-> half_full);
endmodule

// File: tb/tb_dcfifo_pflag.sv
module tb_dcfifo_pflag;
    logic        clk = 1'b0;
    logic        wrst, rrst, wr_req, ofs_load, rd_req, rd_oe, rd_rewind;
    logic [17:0] wr_data;
    logic [17:0] rd_data;
    logic        empty, almost_empty, half_full, almost_full, full;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    dcfifo_pflag dut (
        .wclk(clk), .wrst(wrst), .wr_req(wr_req), .wr_data(wr_data),
        .ofs_load(ofs_load), .rclk(clk), .rrst(rrst), .rd_req(rd_req),
        .rd_oe(rd_oe), .rd_rewind(rd_rewind), .rd_data(rd_data),
        .empty(empty), .almost_empty(almost_empty), .half_full(half_full),
        .almost_full(almost_full), .full(full)
    );

    typedef struct packed {
        logic [11:0] lo;
        logic [11:0] hi;
        logic [11:0] fill;
    } scn_t;

    localparam scn_t SCN [8] = '{
        '{12'd127, 12'd127, 12'd127},
        '{12'd127, 12'd127, 12'd128},
        '{12'd10,  12'd20,  12'd513},
        '{12'd10,  12'd20,  12'd512},
        '{12'd10,  12'd20,  12'd1004},
        '{12'd10,  12'd20,  12'd1003},
        '{12'd0,   12'd0,   12'd1024},
        '{12'd0,   12'd0,   12'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        wrst = 1; rrst = 1; wr_req = 0; ofs_load = 0; rd_req = 0;
        rd_oe = 1; rd_rewind = 0; wr_data = '0;
        repeat (3) step();
        wrst = 0; rrst = 0;
        step();
    endtask

    task automatic push(input logic [17:0] d);
        wr_req = 1; wr_data = d; step(); wr_req = 0;
    endtask

    task automatic pop(output logic [17:0] d);
        rd_req = 1; step(); rd_req = 0; d = rd_data;
    endtask

    function automatic logic [17:0] pat(input int s, input int k);
        return 18'((k * 37 + s * 1000 + 5) & 32'h3FFFF);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired before the run completed");
        finish_run();
    end

    initial begin
        logic [17:0] got;
        int          mism;

        // Reset state
        do_reset();
        check("R10 data after reset", rd_data, 0);
        check("R10 empty after reset", empty, 1);
        check("R10 almost_empty after reset", almost_empty, 1);
        check("R10 full after reset", full, 0);
        check("R10 almost_full after reset", almost_full, 0);
        check("R10 half_full after reset", half_full, 0);
        ofs_load = 1; rd_req = 1;
        step(); check("R10 default low offset", rd_data, 127);
        step(); check("R10 default high offset", rd_data, 127);
        ofs_load = 0; rd_req = 0;

        // Table of threshold scenarios
        for (int s = 0; s < 8; s++) begin
            int cnt;
            do_reset();
            ofs_load = 1; wr_req = 1;
            wr_data = 18'(SCN[s].lo); step();
            wr_data = 18'(SCN[s].hi); step();
            ofs_load = 0; wr_req = 0;
            ofs_load = 1; rd_req = 1;
            step(); check("R9 readback low offset", rd_data, 32'(SCN[s].lo));
            step(); check("R9 readback high offset", rd_data, 32'(SCN[s].hi));
            ofs_load = 0; rd_req = 0;
            cnt = int'(SCN[s].fill);
            wr_req = 1;
            for (int k = 0; k < cnt; k++) begin
                wr_data = pat(s, k);
                step();
            end
            wr_req = 0;
            if (cnt == 1024) push(18'h2AAAA); // R3 overflow attempt
            repeat (4) step();
            check("R2 empty at level", empty, (cnt == 0) ? 1 : 0);
            check("R5 almost_empty at level", almost_empty, (cnt <= int'(SCN[s].lo)) ? 1 : 0);
            check("R7 half_full at level", half_full, (cnt >= 513) ? 1 : 0);
            check("R6 almost_full at level", almost_full, ((1024 - cnt) <= int'(SCN[s].hi)) ? 1 : 0);
            check("R3 full at level", full, (cnt == 1024) ? 1 : 0);
            mism = 0;
            rd_req = 1;
            for (int k = 0; k < cnt; k++) begin
                step();
                if (rd_data !== pat(s, k)) mism++;
            end
            rd_req = 0;
            check("R1 drained words in order (mismatch count)", mism, 0);
            repeat (3) step();
            check("R3 empty after drain, overflow write ignored", empty, 1);
        end

        // Empty-flag latency across the synchronizer
        do_reset();
        push(18'h1A5A5);
        check("R2 empty one edge after write", empty, 1);
        step(); check("R2 empty two edges after write", empty, 1);
        step(); check("R2 empty clear after second read edge", empty, 0);
        pop(got); check("R1 first word after empty clears", got, 18'h1A5A5);

        // Read of empty buffer is ignored
        repeat (3) step();
        pop(got); check("R4 output holds on empty read", got, 18'h1A5A5);
        push(18'h0BEEF);
        repeat (3) step();
        pop(got); check("R4 next written word is next read", got, 18'h0BEEF);

        // Output enable
        rd_oe = 0; #1; check("R12 output gated low", rd_data, 0);
        rd_oe = 1; #1; check("R12 output restored", rd_data, 18'h0BEEF);

        // Retransmit
        do_reset();
        wr_req = 1;
        for (int k = 0; k < 5; k++) begin
            wr_data = pat(9, k);
            step();
        end
        wr_req = 0;
        repeat (3) step();
        for (int k = 0; k < 3; k++) begin
            pop(got); check("R1 read before rewind", got, pat(9, k));
        end
        rd_rewind = 1; step(); rd_rewind = 0;
        step();
        check("R11 not empty after rewind", empty, 0);
        pop(got); check("R11 first word after rewind", got, pat(9, 0));
        pop(got); check("R11 second word after rewind", got, pat(9, 1));

        // Offset load alternation and no storage write
        do_reset();
        ofs_load = 1; wr_req = 1;
        wr_data = 18'd5;   step();
        wr_data = 18'd900; step();
        wr_data = 18'h3F003; step();
        ofs_load = 0; wr_req = 0;
        repeat (3) step();
        check("R8 load writes no word", empty, 1);
        ofs_load = 1; rd_req = 1;
        step(); check("R8 third load wraps to low offset", rd_data, 3);
        step(); check("R8 high offset kept", rd_data, 900);
        ofs_load = 0; rd_req = 0;
        check("R5 almost_empty with low offset 3", almost_empty, 1);

        finish_run();
    end
endmodule